// File: doc/BRIEF.md
# Locked Serial-ROM Word Reader

This block fetches one 32-bit word from a serial boot ROM. The ROM sits behind a register-mapped controller that other agents also use, so every access is guarded by a hardware semaphore. A client hands the block a byte address. The block then carries out the whole transaction over a simple single-outstanding register bus:

- it takes the semaphore and stamps the owner register;
- it programs the controller for a fast-read command and polls the status register until the controller reports completion;
- it puts the count registers back to idle, reads the data register and gives the semaphore back.

The client receives the word together with an error flag. Lock acquisition is bounded, and so is the completion poll. A polling timeout still gives the semaphore back before the error is reported. A spacing parameter, counted in clock cycles, keeps the controller from seeing its two count registers written back to back.

Top module: `romrd_locked_master`

## Requirements
- R1: After reset `req_ready` is 1. A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is 0 from the next cycle up to the cycle in which `rsp_valid` is high, and it is 1 again in that cycle.
- R2: The first bus access of a request reads the acquire register at `SEM_BASE+0x0`. Only a read value of exactly 1 grants the lock; any other value (for example 3 or 0x8000_0001) makes the block re-read that register.
- R3: If `LOCK_TRIES` acquire reads return no grant, the block ends the request with `rsp_err`=1 and `rsp_data`=0. It issues no write and no release read.
- R4: The first access after a grant writes `OWNER_ID` to the owner register at `SEM_BASE+0x8`, before any controller register is touched.
- R5: The controller is then programmed in this order: write the byte address (zero-extended) to `CTRL_BASE+0x00`, 3 to the address-byte count at `CTRL_BASE+0x04`, 0 to the dummy-byte count at `CTRL_BASE+0x08`, and 0x0B to the opcode register at `CTRL_BASE+0x0C`.
- R6: Any write that follows an address-byte-count write is requested no sooner than `SETTLE_CYCLES` clock cycles after that earlier write was acknowledged.
- R7: Completion is bit 1 of the status register at `CTRL_BASE+0x10`, and all other status bits are ignored. The block polls at most `POLL_LIMIT` times. Completion seen on poll number `POLL_LIMIT` still counts as success.
- R8: After completion the block writes 0 to the address-byte count, waits the settle gap, writes 0 to the dummy-byte count, and then reads `CTRL_BASE+0x14`. `rsp_data` carries that value, with `rsp_err`=0.
- R9: Once the lock has been granted, the last bus access of the request is exactly one read of the release register at `SEM_BASE+0x4`. This holds after success and after a poll timeout.
- R10: After `POLL_LIMIT` polls without completion, the block skips the count restore and the data read, releases the lock, and responds with `rsp_err`=1 and `rsp_data`=0.
- R11: `bus_req` stays high with stable `bus_we`, `bus_addr` and `bus_wdata` until `bus_ack`. It drops in the cycle after the acknowledge. Only one access is ever outstanding.
- R12: `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request |
| req_addr | input | RA_W | ROM byte address |
| req_ready | output | 1 | Idle, request can be taken |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Lock or completion timeout |
| rsp_data | output | DW | Word read from ROM |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access complete (one-cycle pulse) |
| bus_rdata | input | DW | Read data, valid with bus_ack |

## Verification
Two decisions can collide in the same cycle. A lock grant can arrive on the very last permitted acquire read, and the completion bit can arrive on the very last permitted poll. In both cases success and give-up are resolved on the same acknowledge. The bench model grants on exactly attempt `LOCK_TRIES` and signals completion on exactly poll `POLL_LIMIT`, and it also runs the case one step later. The outcome is judged from the logged bus trace (number of acquire and status reads, presence of the restore writes and the release read) and from the response error flag.

// File: rtl/romrd_pkg.sv
package romrd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LOCK,
    S_OWNER,
    S_ADDR,
    S_ABYTE,
    S_GAP_A,
    S_DUMMY,
    S_OPCODE,
    S_POLL,
    S_ACLR,
    S_GAP_B,
    S_DCLR,
    S_FETCH,
    S_UNLOCK
  } seq_state_t;

  // semaphore block register offsets
  localparam logic [7:0] SEM_OFF_ACQ   = 8'h00;
  localparam logic [7:0] SEM_OFF_REL   = 8'h04;
  localparam logic [7:0] SEM_OFF_OWNER = 8'h08;

  // ROM controller register offsets
  localparam logic [7:0] CTL_OFF_ADDR  = 8'h00;
  localparam logic [7:0] CTL_OFF_ABYTE = 8'h04;
  localparam logic [7:0] CTL_OFF_DUMMY = 8'h08;
  localparam logic [7:0] CTL_OFF_OPC   = 8'h0C;
  localparam logic [7:0] CTL_OFF_STAT  = 8'h10;
  localparam logic [7:0] CTL_OFF_RDATA = 8'h14;

  localparam logic [7:0] FAST_READ_OP  = 8'h0B;
  localparam logic [7:0] ADDR_BYTES_ON = 8'd3;
  localparam int         DONE_BIT      = 1;

endpackage

// File: rtl/romrd_bus_port.sv
module romrd_bus_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_done,
  output logic [DW-1:0] cmd_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      cmd_done  <= 1'b0;
      cmd_rdata <= '0;
    end else begin
      cmd_done <= 1'b0;
      if (bus_req && bus_ack) begin
        bus_req  <= 1'b0;
        cmd_done <= 1'b1;
        if (!bus_we) cmd_rdata <= bus_rdata;
      end else if (go && !bus_req) begin
        bus_req   <= 1'b1;
        bus_we    <= cmd_we;
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_wdata;
      end
    end
  end

  // R11: fields frozen while an access waits for its acknowledge
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R11: request drops right after the acknowledge
  a_r11_drop: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req);

  // R11: a new access is never started on top of an open one
  a_r11_single: assert property (@(posedge clk) disable iff (rst)
    go |-> !bus_req);

endmodule

// File: rtl/romrd_settle_timer.sv
module romrd_settle_timer #(
  parameter int CYCLES = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (start) begin
        cnt <= LOAD;
        run <= 1'b1;
      end else if (run) begin
        if (cnt <= CW'(1)) begin
          run  <= 1'b0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  // R6: a started gap is not cut short by a restart
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    run |-> !start);

endmodule

// File: rtl/romrd_sequencer.sv
module romrd_sequencer
  import romrd_pkg::*;
#(
  parameter int          AW            = 32,
  parameter int          DW            = 32,
  parameter int          RA_W          = 24,
  parameter logic [31:0] SEM_BASE      = 32'h0001_0000,
  parameter logic [31:0] CTRL_BASE     = 32'h0002_0000,
  parameter logic [31:0] OWNER_ID      = 32'h0000_00D5,
  parameter int          LOCK_TRIES    = 10000,
  parameter int          POLL_LIMIT    = 100,
  parameter int          SETTLE_CYCLES = 12500
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [RA_W-1:0] req_addr,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [DW-1:0]   rsp_data,
  output logic            go,
  output logic            cmd_we,
  output logic [AW-1:0]   cmd_addr,
  output logic [DW-1:0]   cmd_wdata,
  input  logic            cmd_done,
  input  logic [DW-1:0]   cmd_rdata,
  output logic            tmr_start,
  input  logic            tmr_fire
);

  localparam int TRY_W = $clog2(LOCK_TRIES + 1);
  localparam int POL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [TRY_W-1:0] TRY_MAX = TRY_W'(LOCK_TRIES - 1);
  localparam logic [POL_W-1:0] POL_MAX = POL_W'(POLL_LIMIT - 1);

  localparam logic [AW-1:0] A_ACQ   = AW'(SEM_BASE  + 32'(SEM_OFF_ACQ));
  localparam logic [AW-1:0] A_REL   = AW'(SEM_BASE  + 32'(SEM_OFF_REL));
  localparam logic [AW-1:0] A_OWNER = AW'(SEM_BASE  + 32'(SEM_OFF_OWNER));
  localparam logic [AW-1:0] A_ADDR  = AW'(CTRL_BASE + 32'(CTL_OFF_ADDR));
  localparam logic [AW-1:0] A_ABYTE = AW'(CTRL_BASE + 32'(CTL_OFF_ABYTE));
  localparam logic [AW-1:0] A_DUMMY = AW'(CTRL_BASE + 32'(CTL_OFF_DUMMY));
  localparam logic [AW-1:0] A_OPC   = AW'(CTRL_BASE + 32'(CTL_OFF_OPC));
  localparam logic [AW-1:0] A_STAT  = AW'(CTRL_BASE + 32'(CTL_OFF_STAT));
  localparam logic [AW-1:0] A_RDATA = AW'(CTRL_BASE + 32'(CTL_OFF_RDATA));

  seq_state_t       state;
  logic             wait_q;
  logic             err_q;
  logic [RA_W-1:0]  addr_q;
  logic [DW-1:0]    data_q;
  logic [TRY_W-1:0] tries;
  logic [POL_W-1:0] polls;
  logic             in_gap;

  assign req_ready = (state == S_IDLE);
  assign in_gap    = (state == S_GAP_A) || (state == S_GAP_B);

  // command for the current step
  always_comb begin
    cmd_we    = 1'b0;
    cmd_addr  = '0;
    cmd_wdata = '0;
    unique case (state)
      S_LOCK:   cmd_addr = A_ACQ;
      S_OWNER:  begin cmd_we = 1'b1; cmd_addr = A_OWNER; cmd_wdata = DW'(OWNER_ID);      end
      S_ADDR:   begin cmd_we = 1'b1; cmd_addr = A_ADDR;  cmd_wdata = DW'(addr_q);        end
      S_ABYTE:  begin cmd_we = 1'b1; cmd_addr = A_ABYTE; cmd_wdata = DW'(ADDR_BYTES_ON); end
      S_DUMMY:  begin cmd_we = 1'b1; cmd_addr = A_DUMMY; cmd_wdata = '0;                 end
      S_OPCODE: begin cmd_we = 1'b1; cmd_addr = A_OPC;   cmd_wdata = DW'(FAST_READ_OP);  end
      S_POLL:   cmd_addr = A_STAT;
      S_ACLR:   begin cmd_we = 1'b1; cmd_addr = A_ABYTE; cmd_wdata = '0;                 end
      S_DCLR:   begin cmd_we = 1'b1; cmd_addr = A_DUMMY; cmd_wdata = '0;                 end
      S_FETCH:  cmd_addr = A_RDATA;
      S_UNLOCK: cmd_addr = A_REL;
      default:  cmd_addr = '0;
    endcase
    go        = (state != S_IDLE) && !in_gap && !wait_q;
    tmr_start = in_gap && !wait_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      wait_q    <= 1'b0;
      err_q     <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      tries     <= '0;
      polls     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (state == S_IDLE) begin
        if (req_valid) begin
          addr_q <= req_addr;
          tries  <= '0;
          polls  <= '0;
          err_q  <= 1'b0;
          data_q <= '0;
          wait_q <= 1'b0;
          state  <= S_LOCK;
        end
      end else if (!wait_q) begin
        wait_q <= 1'b1;
      end else if (cmd_done || tmr_fire) begin
        wait_q <= 1'b0;
        unique case (state)
          S_LOCK: begin
            if (cmd_rdata == DW'(1)) begin
              state <= S_OWNER;
            end else if (tries == TRY_MAX) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_data  <= '0;
              state     <= S_IDLE;
            end else begin
              tries <= tries + TRY_W'(1);
            end
          end
          S_OWNER:  state <= S_ADDR;
          S_ADDR:   state <= S_ABYTE;
          S_ABYTE:  state <= S_GAP_A;
          S_GAP_A:  state <= S_DUMMY;
          S_DUMMY:  state <= S_OPCODE;
          S_OPCODE: state <= S_POLL;
          S_POLL: begin
            if (cmd_rdata[DONE_BIT]) begin
              state <= S_ACLR;
            end else if (polls == POL_MAX) begin
              err_q <= 1'b1;
              state <= S_UNLOCK;
            end else begin
              polls <= polls + POL_W'(1);
            end
          end
          S_ACLR:   state <= S_GAP_B;
          S_GAP_B:  state <= S_DCLR;
          S_DCLR:   state <= S_FETCH;
          S_FETCH: begin
            data_q <= cmd_rdata;
            state  <= S_UNLOCK;
          end
          S_UNLOCK: begin
            rsp_valid <= 1'b1;
            rsp_err   <= err_q;
            rsp_data  <= err_q ? '0 : data_q;
            state     <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // checker: cycles since the last address-byte-count write was acknowledged
  localparam int GW = $clog2(SETTLE_CYCLES + 2);
  logic [GW-1:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= GW'(SETTLE_CYCLES);
    end else if (cmd_done && wait_q && (state == S_ABYTE || state == S_ACLR)) begin
      gap_cnt <= '0;
    end else if (gap_cnt < GW'(SETTLE_CYCLES)) begin
      gap_cnt <= gap_cnt + GW'(1);
    end
  end

  // R6: dummy-count write never issued before the settle window has run out
  a_r6_gap: assert property (@(posedge clk) disable iff (rst)
    go && (state == S_DUMMY || state == S_DCLR) |-> gap_cnt >= GW'(SETTLE_CYCLES));

  // R3: acquire attempts stay within the configured bound
  a_r3_try_bound: assert property (@(posedge clk) disable iff (rst)
    tries <= TRY_MAX);

  // R7: poll count stays within the configured bound
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (rst)
    polls <= POL_MAX);

  // R9: a poll timeout always leads through the release step
  a_r9_release_after_timeout: assert property (@(posedge clk) disable iff (rst)
    state == S_POLL && cmd_done && wait_q && !cmd_rdata[DONE_BIT] && polls == POL_MAX
    |=> state == S_UNLOCK);

endmodule

// File: rtl/romrd_locked_master.sv
module romrd_locked_master #(
  parameter int          AW            = 32,
  parameter int          DW            = 32,
  parameter int          RA_W          = 24,
  parameter logic [31:0] SEM_BASE      = 32'h0001_0000,
  parameter logic [31:0] CTRL_BASE     = 32'h0002_0000,
  parameter logic [31:0] OWNER_ID      = 32'h0000_00D5,
  parameter int          LOCK_TRIES    = 10000,
  parameter int          POLL_LIMIT    = 100,
  parameter int          SETTLE_CYCLES = 12500
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [RA_W-1:0] req_addr,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [DW-1:0]   rsp_data,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata
);

  logic          go;
  logic          cmd_we;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          cmd_done;
  logic [DW-1:0] cmd_rdata;
  logic          tmr_start;
  logic          tmr_fire;

  romrd_sequencer #(
    .AW(AW), .DW(DW), .RA_W(RA_W),
    .SEM_BASE(SEM_BASE), .CTRL_BASE(CTRL_BASE), .OWNER_ID(OWNER_ID),
    .LOCK_TRIES(LOCK_TRIES), .POLL_LIMIT(POLL_LIMIT), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .go(go), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .tmr_start(tmr_start), .tmr_fire(tmr_fire)
  );

  romrd_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst),
    .go(go), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  romrd_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_gap (
    .clk(clk), .rst(rst), .start(tmr_start), .fire(tmr_fire)
  );

  // R1: ready drops the cycle after a request is taken
  a_r1_ready_drop: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R1: ready comes back only together with a response
  a_r1_ready_return: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> !req_ready || rsp_valid);

  // R12: the response strobe lasts one cycle
  a_r12_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R10: an error response carries no data
  a_r10_err_data: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_data == '0);

  // R11: no register access while idle and unanswered
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready && !rsp_valid && !$past(rsp_valid) |-> !bus_req);

endmodule

// File: tb/tb_romrd_locked_master.sv
module tb_romrd_locked_master;

  localparam int          AW      = 32;
  localparam int          DW      = 32;
  localparam int          RA_W    = 24;
  localparam logic [31:0] SEMB    = 32'h0001_0000;
  localparam logic [31:0] CTLB    = 32'h0002_0000;
  localparam logic [31:0] OWN     = 32'h0000_00D5;
  localparam int          TRIES   = 20;
  localparam int          POLLS   = 8;
  localparam int          SETTLE  = 12;

  localparam logic [31:0] R_ACQ   = SEMB + 32'h0;
  localparam logic [31:0] R_REL   = SEMB + 32'h4;
  localparam logic [31:0] R_OWN   = SEMB + 32'h8;
  localparam logic [31:0] R_ADDR  = CTLB + 32'h00;
  localparam logic [31:0] R_ABYTE = CTLB + 32'h04;
  localparam logic [31:0] R_DUMMY = CTLB + 32'h08;
  localparam logic [31:0] R_OPC   = CTLB + 32'h0C;
  localparam logic [31:0] R_STAT  = CTLB + 32'h10;
  localparam logic [31:0] R_RDATA = CTLB + 32'h14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [RA_W-1:0] req_addr = '0;
  logic            req_ready, rsp_valid, rsp_err;
  logic [DW-1:0]   rsp_data;
  logic            bus_req, bus_we;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata;
  logic            bus_ack = 1'b0;
  logic [DW-1:0]   bus_rdata = '0;

  always #4 clk = ~clk;

  romrd_locked_master #(
    .AW(AW), .DW(DW), .RA_W(RA_W), .SEM_BASE(SEMB), .CTRL_BASE(CTLB), .OWNER_ID(OWN),
    .LOCK_TRIES(TRIES), .POLL_LIMIT(POLLS), .SETTLE_CYCLES(SETTLE)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  // slave model configuration
  int          lat = 0;
  int          deny_left = 0;
  logic [31:0] deny_val = 32'h0;
  int          done_after = 0;
  logic [31:0] rom_word = 32'h0;
  int          polls_seen = 0;

  // trace log
  int          cyc = 0;
  int          wcnt = 0;
  int          cur_start = 0;
  int          log_n = 0;
  logic        log_we   [0:255];
  logic [31:0] log_addr [0:255];
  logic [31:0] log_wd   [0:255];
  int          log_st   [0:255];
  int          log_end  [0:255];

  // expected trace
  int          exp_n = 0;
  logic        exp_we   [0:255];
  logic [31:0] exp_addr [0:255];
  logic [31:0] exp_wd   [0:255];

  always @(posedge clk) begin
    logic [31:0] rv;
    cyc = cyc + 1;
    if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_req) begin
      if (wcnt == 0) cur_start = cyc;
      if (wcnt >= lat) begin
        wcnt = 0;
        rv = 32'h0;
        if (!bus_we) begin
          if (bus_addr == R_ACQ) begin
            if (deny_left > 0) begin deny_left = deny_left - 1; rv = deny_val; end
            else rv = 32'h1;
          end else if (bus_addr == R_STAT) begin
            if (done_after >= 0 && polls_seen >= done_after) rv = 32'h0000_0002;
            else rv = 32'hFFFF_FFFD;
            polls_seen = polls_seen + 1;
          end else if (bus_addr == R_RDATA) begin
            rv = rom_word;
          end
        end
        if (log_n < 256) begin
          log_we[log_n]   = bus_we;
          log_addr[log_n] = bus_addr;
          log_wd[log_n]   = bus_wdata;
          log_st[log_n]   = cur_start;
          log_end[log_n]  = cyc;
          log_n = log_n + 1;
        end
        bus_rdata <= rv;
        bus_ack   <= 1'b1;
      end else begin
        wcnt = wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic prep(input int l, input int dl, input logic [31:0] dv,
                      input int da, input logic [31:0] w);
    lat = l; deny_left = dl; deny_val = dv; done_after = da; rom_word = w;
    polls_seen = 0; log_n = 0; exp_n = 0;
  endtask

  task automatic ex(input logic we, input logic [31:0] a, input logic [31:0] d);
    exp_we[exp_n] = we; exp_addr[exp_n] = a; exp_wd[exp_n] = d; exp_n++;
  endtask

  task automatic ex_prog(input logic [31:0] a, input int lock_reads);
    for (int i = 0; i < lock_reads; i++) ex(1'b0, R_ACQ, 32'h0);
    ex(1'b1, R_OWN, OWN);
    ex(1'b1, R_ADDR, a);
    ex(1'b1, R_ABYTE, 32'd3);
    ex(1'b1, R_DUMMY, 32'd0);
    ex(1'b1, R_OPC, 32'h0B);
  endtask

  task automatic ex_tail_ok(input int polls);
    for (int i = 0; i < polls; i++) ex(1'b0, R_STAT, 32'h0);
    ex(1'b1, R_ABYTE, 32'd0);
    ex(1'b1, R_DUMMY, 32'd0);
    ex(1'b0, R_RDATA, 32'h0);
    ex(1'b0, R_REL, 32'h0);
  endtask

  task automatic cmp_trace(input string req);
    chk(log_n == exp_n, req, "access count", 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (log_we[i] != exp_we[i] || log_addr[i] != exp_addr[i] ||
          (exp_we[i] && log_wd[i] != exp_wd[i])) begin
        chk(1'b0, req, $sformatf("access %0d addr/data", i), log_addr[i] ^ log_wd[i],
            exp_addr[i] ^ exp_wd[i]);
        break;
      end
    end
  endtask

  task automatic cmp_gaps();
    for (int i = 1; i < log_n; i++) begin
      if (log_we[i] && log_we[i-1] && log_addr[i-1] == R_ABYTE)
        chk(log_st[i] - log_end[i-1] >= SETTLE, "R6", "gap after count write",
            32'(log_st[i] - log_end[i-1]), 32'(SETTLE));
    end
  endtask

  task automatic run_req(input logic [RA_W-1:0] a, output logic [31:0] d,
                         output logic e, output int ready_bad, output int strobe_bad);
    ready_bad = 0; strobe_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) ready_bad++;
      @(negedge clk);
    end
    if (!req_ready) ready_bad++;
    d = rsp_data; e = rsp_err;
    @(negedge clk);
    if (rsp_valid) strobe_bad++;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R12", "no strobe after reset", 32'(rsp_valid), 32'h0);
    chk(bus_req == 1'b0, "R11", "bus quiet after reset", 32'(bus_req), 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d; logic e; int rb, sb;
    prep(0, 0, 32'h0, 2, 32'hA5A5_1234);
    run_req(24'h004008, d, e, rb, sb);
    ex_prog(32'h0000_4008, 1);
    ex_tail_ok(3);
    cmp_trace("R5");
    cmp_gaps();
    chk(d == 32'hA5A5_1234, "R8", "read data", d, 32'hA5A5_1234);
    chk(e == 1'b0, "R8", "no error", 32'(e), 32'h0);
    chk(rb == 0, "R1", "ready low while busy", 32'(rb), 32'h0);
    chk(sb == 0, "R12", "strobe one cycle", 32'(sb), 32'h0);
  endtask

  task automatic t_lock_retry();
    logic [31:0] d; logic e; int rb, sb;
    prep(2, 5, 32'h8000_0001, 0, 32'h1357_9BDF);
    run_req(24'hABCDEF, d, e, rb, sb);
    ex_prog(32'h00AB_CDEF, 6);
    ex_tail_ok(1);
    cmp_trace("R2");
    chk(log_we[6] && log_addr[6] == R_OWN, "R4", "owner write follows grant", log_addr[6], R_OWN);
    cmp_gaps();
    chk(d == 32'h1357_9BDF && !e, "R2", "data after retried lock", d, 32'h1357_9BDF);
  endtask

  task automatic t_lock_fail();
    logic [31:0] d; logic e; int rb, sb; int writes;
    prep(1, TRIES, 32'h3, 0, 32'hDEAD_BEEF);
    run_req(24'h000010, d, e, rb, sb);
    for (int i = 0; i < TRIES; i++) ex(1'b0, R_ACQ, 32'h0);
    cmp_trace("R3");
    writes = 0;
    for (int i = 0; i < log_n; i++) if (log_we[i] || log_addr[i] == R_REL) writes++;
    chk(writes == 0, "R3", "no write or release", 32'(writes), 32'h0);
    chk(e == 1'b1, "R3", "error flag", 32'(e), 32'h1);
    chk(d == 32'h0, "R3", "zero data", d, 32'h0);
    chk(rb == 0 && sb == 0, "R12", "handshake on lock failure", 32'(rb + sb), 32'h0);
    deny_left = 0;
  endtask

  task automatic t_lock_last();
    logic [31:0] d; logic e; int rb, sb;
    prep(0, TRIES - 1, 32'h0, 0, 32'h0F0F_F0F0);
    run_req(24'h000100, d, e, rb, sb);
    ex_prog(32'h0000_0100, TRIES);
    ex_tail_ok(1);
    cmp_trace("R3");
    chk(!e && d == 32'h0F0F_F0F0, "R2", "grant on last attempt", d, 32'h0F0F_F0F0);
  endtask

  task automatic t_poll_last();
    logic [31:0] d; logic e; int rb, sb;
    prep(1, 0, 32'h0, POLLS - 1, 32'h2468_ACE0);
    run_req(24'h00FFFC, d, e, rb, sb);
    ex_prog(32'h0000_FFFC, 1);
    ex_tail_ok(POLLS);
    cmp_trace("R7");
    cmp_gaps();
    chk(!e && d == 32'h2468_ACE0, "R7", "done on last poll", d, 32'h2468_ACE0);
  endtask

  task automatic t_poll_timeout();
    logic [31:0] d; logic e; int rb, sb;
    prep(0, 0, 32'h0, POLLS, 32'h7777_7777);
    run_req(24'h000020, d, e, rb, sb);
    ex_prog(32'h0000_0020, 1);
    for (int i = 0; i < POLLS; i++) ex(1'b0, R_STAT, 32'h0);
    ex(1'b0, R_REL, 32'h0);
    cmp_trace("R10");
    chk(log_n > 0 && log_addr[log_n-1] == R_REL && !log_we[log_n-1], "R9",
        "release is last access", log_addr[log_n-1], R_REL);
    chk(e == 1'b1, "R10", "timeout error", 32'(e), 32'h1);
    chk(d == 32'h0, "R10", "timeout data", d, 32'h0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] d; logic e; int rb, sb;
    prep(3, 0, 32'h0, 1, 32'hC0DE_0001);
    run_req(24'h000004, d, e, rb, sb);
    chk(!e && d == 32'hC0DE_0001, "R11", "slow bus read", d, 32'hC0DE_0001);
    prep(0, 0, 32'h0, 0, 32'hC0DE_0002);
    run_req(24'h000008, d, e, rb, sb);
    ex_prog(32'h0000_0008, 1);
    ex_tail_ok(1);
    cmp_trace("R9");
    chk(!e && d == 32'hC0DE_0002, "R8", "second request data", d, 32'hC0DE_0002);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lock_retry();
    t_lock_fail();
    t_lock_last();
    t_poll_last();
    t_poll_timeout();
    t_back_to_back();
    finish_run();
  end

endmodule